// File: doc/BRIEF.md
# Wake-on-LAN Magic Frame Detector

This block watches a received Ethernet byte stream and raises a wake request when a frame carries the wake pattern. The pattern is a sync run of at least six 0xFF bytes, followed at once by sixteen copies of the station's 6-byte address. Nothing may sit between the copies. The pattern may start anywhere in the frame body after the 12 header bytes, which are the destination and source addresses. The frame is considered at all only if its destination is this station or a multicast group. A found pattern is held until the frame ends. It becomes a wake request only if the frame's CRC was reported good.

The receive side supplies one byte per cycle, qualified by `rx_valid`. `rx_sof` marks the first byte of a frame. `rx_eof` marks the last byte, and `rx_crc_ok` is sampled with it. Two enable bits must both be set to arm the detector. The output `wake_n` is active low and sticky. Software releases it with a pulse on `wake_clear`.

The frame tracker is a five-state machine:
- `F_IDLE` waits for a start of frame.
- `F_HDR` counts the 12 header bytes.
- `F_BODY` scans the payload.
- `F_HELD` holds a found pattern until end of frame.
- `F_SKIP` ignores a frame whose destination is not accepted.

Transitions:
- Any state goes to `F_HDR` on a start-of-frame byte.
- `F_HDR` goes to `F_BODY` or `F_SKIP` on its 12th byte, depending on the destination filter.
- `F_BODY` goes to `F_HELD` on the last byte of the sixteenth copy.
- Any state goes to `F_IDLE` on an end-of-frame byte, or when the detector is disarmed.

The pattern scanner has two states:
- `S_SYNC` counts consecutive 0xFF bytes.
- `S_REP` matches address bytes.

Scanner transitions:
- `S_SYNC` goes to `S_REP` on the first non-0xFF byte after at least six 0xFF bytes, provided that byte equals address byte 0.
- `S_REP` goes back to `S_SYNC` on any mismatch, or on completion of the sixteenth copy.

Top module: `wol_frame_detector`

## Requirements
- R1: The sync run must be at least six consecutive 0xFF bytes directly before the first address copy. Longer runs are accepted. A run of five gives no wake.
- R2: The address must follow the sync as 16 consecutive copies, 96 bytes in total. Each copy starts with `station_addr[47:40]` and ends with `station_addr[7:0]`. Fifteen copies, or a corrupted byte in any copy, give no wake. The address is unicast, so its first byte is never 0xFF.
- R3: The pattern is found at any byte offset of the body, which starts after frame byte 11 (0-based). Any bytes may come before and after it.
- R4: A frame is a candidate only if its first six bytes equal the station address, or if bit 0 of its first byte is 1 (multicast or broadcast). Any other frame never causes a wake.
- R5: A found pattern asserts `wake_n` low one clock after the edge that takes the end-of-frame byte, and only if `rx_crc_ok` is 1 on that byte. With `rx_crc_ok` at 0 the match is discarded.
- R6: A new start-of-frame before the end of frame discards any pending match.
- R7: The detector is armed only while both `wake_global_en` and `wake_magic_en` are 1. While disarmed, no wake is raised. Dropping either enable releases `wake_n` high on the next clock and clears all match state.
- R8: Once low, `wake_n` stays low until a one-cycle `wake_clear` pulse, then reads high on the next clock. After reset `wake_n` is high.
- R9: A mismatch during the copies restarts the sync search. If the mismatching byte is 0xFF, it counts toward a new sync run, so a valid pattern that starts there is still found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte qualifier |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_crc_ok | input | 1 | CRC good, sampled with `rx_eof` |
| rx_byte | input | 8 | Received byte |
| station_addr | input | 48 | Station address, bits 47:40 sent first |
| wake_global_en | input | 1 | Global wake enable |
| wake_magic_en | input | 1 | Magic frame wake enable |
| wake_clear | input | 1 | Software clear pulse for the wake request |
| wake_n | output | 1 | Sticky active-low wake request |

## Verification
The only result is `wake_n`, and it is due exactly one clock after the rising edge that takes a frame's end-of-frame byte. A clear or a disarm also takes effect one clock after the edge that samples it. The bench drives every input on falling edges. A monitor records at each rising edge whether an end-of-frame byte was taken, and compares `wake_n` with the queued expectation at the next falling edge, so each frame's verdict is read in the one cycle it becomes due. Stickiness and release are checked by direct falling-edge samples, 20 cycles after a wake and one cycle after a clear or disarm.

// File: rtl/wol_pkg.sv
package wol_pkg;
    typedef enum logic [2:0] {
        F_IDLE,
        F_HDR,
        F_BODY,
        F_HELD,
        F_SKIP
    } frame_st_t;

    typedef enum logic {
        S_SYNC,
        S_REP
    } scan_st_t;
endpackage

// File: rtl/wol_dest_filter.sv
module wol_dest_filter #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic [7:0]              rx_byte,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    cand
);
    localparam int CW = $clog2(ADDR_BYTES + 1);

    logic [CW-1:0] cnt_q;
    logic          eq_q;
    logic          mcast_q;
    logic [7:0]    want;

    always_comb begin
        if (rx_sof)
            want = station_addr[8*ADDR_BYTES-1 -: 8];
        else
            want = station_addr[8*(ADDR_BYTES-1-int'(cnt_q)) +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            eq_q    <= 1'b0;
            mcast_q <= 1'b0;
        end else if (rx_valid && rx_sof) begin
            cnt_q   <= CW'(1);
            eq_q    <= (rx_byte == want);
            mcast_q <= rx_byte[0];
        end else if (rx_valid && cnt_q != '0 && cnt_q < CW'(ADDR_BYTES)) begin
            cnt_q <= cnt_q + CW'(1);
            eq_q  <= eq_q && (rx_byte == want);
        end
    end

    assign cand = (cnt_q == CW'(ADDR_BYTES)) && (eq_q || mcast_q);
endmodule

// File: rtl/wol_pattern_scan.sv
module wol_pattern_scan
    import wol_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int SYNC_LEN   = 6,
    parameter int REPEATS    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    en,
    input  logic [7:0]              rx_byte,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    hit
);
    localparam int FW = $clog2(SYNC_LEN + 1);
    localparam int PW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1;

    scan_st_t      st_q, st_d;
    logic [FW-1:0] ffrun_q, ffrun_d;
    logic [PW-1:0] pos_q, pos_d;
    logic [RW-1:0] rep_q, rep_d;
    logic          is_ff, byte_ok, last_pos, last_rep;
    logic [7:0]    want;

    assign is_ff    = (rx_byte == 8'hFF);
    assign want     = station_addr[8*(ADDR_BYTES-1-int'(pos_q)) +: 8];
    assign byte_ok  = (rx_byte == want);
    assign last_pos = (pos_q == PW'(ADDR_BYTES-1));
    assign last_rep = (rep_q == RW'(REPEATS-1));

    always_comb begin
        st_d    = st_q;
        pos_d   = pos_q;
        rep_d   = rep_q;
        ffrun_d = is_ff ? ((ffrun_q == FW'(SYNC_LEN)) ? ffrun_q : ffrun_q + FW'(1)) : '0;
        unique case (st_q)
            S_SYNC: begin
                if (!is_ff && ffrun_q == FW'(SYNC_LEN) &&
                    rx_byte == station_addr[8*ADDR_BYTES-1 -: 8]) begin
                    st_d  = S_REP;
                    pos_d = PW'(1);
                    rep_d = '0;
                end
            end
            S_REP: begin
                if (!byte_ok) begin
                    st_d  = S_SYNC;
                    pos_d = '0;
                    rep_d = '0;
                end else if (last_pos) begin
                    pos_d = '0;
                    if (last_rep) begin
                        st_d  = S_SYNC;
                        rep_d = '0;
                    end else begin
                        rep_d = rep_q + RW'(1);
                    end
                end else begin
                    pos_d = pos_q + PW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st_q    <= S_SYNC;
            ffrun_q <= '0;
            pos_q   <= '0;
            rep_q   <= '0;
        end else if (en) begin
            st_q    <= st_d;
            ffrun_q <= ffrun_d;
            pos_q   <= pos_d;
            rep_q   <= rep_d;
        end
    end

    assign hit = en && (st_q == S_REP) && byte_ok && last_pos && last_rep;

    // R2 / R1: the copy phase is only entered after a full sync run
    assert_rep_after_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_REP && $past(st_q) == S_SYNC) |-> $past(ffrun_q) == FW'(SYNC_LEN));
endmodule

// File: rtl/wol_frame_detector.sv
module wol_frame_detector
    import wol_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int SYNC_LEN   = 6,
    parameter int REPEATS    = 16,
    parameter int HDR_BYTES  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic                    rx_crc_ok,
    input  logic [7:0]              rx_byte,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    wake_global_en,
    input  logic                    wake_magic_en,
    input  logic                    wake_clear,
    output logic                    wake_n
);
    localparam int HW = $clog2(HDR_BYTES + 1);

    frame_st_t     st_q, st_d;
    logic [HW-1:0] hdr_q;
    logic          armed, cand, hit, scan_en, scan_clr, wake_set, wake_q;

    assign armed    = wake_global_en && wake_magic_en;
    assign scan_clr = !armed || (rx_valid && rx_sof);
    assign scan_en  = armed && rx_valid && !rx_sof && (st_q == F_BODY);

    wol_dest_filter #(.ADDR_BYTES(ADDR_BYTES)) u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_byte      (rx_byte),
        .station_addr (station_addr),
        .cand         (cand)
    );

    wol_pattern_scan #(
        .ADDR_BYTES (ADDR_BYTES),
        .SYNC_LEN   (SYNC_LEN),
        .REPEATS    (REPEATS)
    ) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (scan_clr),
        .en           (scan_en),
        .rx_byte      (rx_byte),
        .station_addr (station_addr),
        .hit          (hit)
    );

    always_comb begin
        st_d = st_q;
        if (!armed) begin
            st_d = F_IDLE;
        end else if (rx_valid && rx_sof) begin
            st_d = rx_eof ? F_IDLE : F_HDR;
        end else if (rx_valid) begin
            unique case (st_q)
                F_IDLE: st_d = F_IDLE;
                F_HDR: begin
                    if (rx_eof)
                        st_d = F_IDLE;
                    else if (hdr_q == HW'(HDR_BYTES-1))
                        st_d = cand ? F_BODY : F_SKIP;
                end
                F_BODY: begin
                    if (rx_eof)
                        st_d = F_IDLE;
                    else if (hit)
                        st_d = F_HELD;
                end
                F_HELD: if (rx_eof) st_d = F_IDLE;
                F_SKIP: if (rx_eof) st_d = F_IDLE;
                default: st_d = F_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= F_IDLE;
            hdr_q <= '0;
        end else begin
            st_q <= st_d;
            if (rx_valid && rx_sof)
                hdr_q <= HW'(1);
            else if (rx_valid && st_q == F_HDR)
                hdr_q <= hdr_q + HW'(1);
        end
    end

    assign wake_set = armed && rx_valid && rx_eof && rx_crc_ok && !rx_sof &&
                      ((st_q == F_HELD) || (st_q == F_BODY && hit));

    always_ff @(posedge clk) begin
        if (!rst_n || !armed)
            wake_q <= 1'b0;
        else if (wake_set)
            wake_q <= 1'b1;
        else if (wake_clear)
            wake_q <= 1'b0;
    end

    assign wake_n = !wake_q;

    // R5: wake only follows a good-CRC end-of-frame byte
    assert_wake_on_good_eof_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_n) |-> $past(rx_valid && rx_eof && rx_crc_ok));
    // R8: wake request is sticky without a clear
    assert_wake_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_n && !wake_clear && armed) |=> !wake_n);
    // R7: disarming releases the request
    assert_disarm_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> wake_n);
    // R4: scanning only for accepted destinations
    assert_body_needs_cand_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == F_BODY && $past(st_q) == F_HDR) |-> $past(cand));
endmodule

// File: tb/test_wol_frame_detector.sv
module test_wol_frame_detector;
    logic        clk = 1'b0;
    logic        rst_n, rx_valid, rx_sof, rx_eof, rx_crc_ok;
    logic [7:0]  rx_byte;
    logic [47:0] station_addr;
    logic        wake_global_en, wake_magic_en, wake_clear;
    logic        wake_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] frm[$];
    bit    exp_q[$];
    string tag_q[$];
    logic  eof_taken = 1'b0;

    localparam logic [47:0] ME = 48'h112233445566;

    always #5 clk = ~clk;

    wol_frame_detector i_wol_frame_detector (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .rx_byte(rx_byte),
        .station_addr(station_addr), .wake_global_en(wake_global_en),
        .wake_magic_en(wake_magic_en), .wake_clear(wake_clear), .wake_n(wake_n)
    );

    task automatic chk(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s wake_n actual %0b expected %0b", req, act, exp);
        end
    endtask

    // monitor: scoreboard comparison one cycle after the eof byte is taken
    always @(posedge clk) eof_taken <= rx_valid && rx_eof;
    always @(negedge clk) begin
        if (eof_taken) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected frame end", wake_n, 1'b1);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(wake_n == !e, t, wake_n, !e);
            end
        end
    end

    task automatic put_addr(input logic [47:0] a);
        for (int k = 0; k < 6; k++) frm.push_back(a[47-8*k -: 8]);
    endtask

    task automatic put_fill(input int n);
        for (int k = 0; k < n; k++) frm.push_back(8'h20 + 8'(k % 64));
    endtask

    task automatic put_pattern(input int nsync, input int nreps, input int bad_rep);
        for (int k = 0; k < nsync; k++) frm.push_back(8'hFF);
        for (int r = 1; r <= nreps; r++)
            for (int k = 0; k < 6; k++)
                frm.push_back((r == bad_rep && k == 2) ? (ME[47-8*k -: 8] ^ 8'h5A)
                                                       : ME[47-8*k -: 8]);
    endtask

    task automatic build(input logic [47:0] dst, input int pre, input int nsync,
                         input int nreps, input int bad_rep, input int post);
        frm.delete();
        put_addr(dst);
        put_addr(48'h02AABBCCDDEE);
        put_fill(pre);
        put_pattern(nsync, nreps, bad_rep);
        put_fill(post);
    endtask

    task automatic drive(input bit crc_ok, input bit with_eof);
        for (int i = 0; i < frm.size(); i++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_byte   = frm[i];
            rx_sof    = (i == 0);
            rx_eof    = with_eof && (i == frm.size() - 1);
            rx_crc_ok = crc_ok && rx_eof;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0;
    endtask

    task automatic clear_pulse();
        @(negedge clk); wake_clear = 1'b1;
        @(negedge clk); wake_clear = 1'b0;
    endtask

    task automatic frame(input bit exp, input string t, input bit crc_ok);
        exp_q.push_back(exp);
        tag_q.push_back(t);
        drive(crc_ok, 1'b1);
        repeat (2) @(negedge clk);
        clear_pulse();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0;
        rx_byte = 8'h00; station_addr = ME; wake_global_en = 1'b1; wake_magic_en = 1'b1;
        wake_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wake_n == 1'b1, "R8 reset state", wake_n, 1'b1);

        build(ME, 0, 6, 16, 0, 4);        frame(1'b1, "R3 offset 0", 1'b1);
        build(ME, 37, 6, 16, 0, 0);       frame(1'b1, "R3 offset 37", 1'b1);
        build(ME, 200, 6, 16, 0, 50);     frame(1'b1, "R3 offset 200", 1'b1);
        build(ME, 10, 6, 15, 0, 10);      frame(1'b0, "R2 fifteen copies", 1'b1);
        build(ME, 10, 6, 16, 9, 10);      frame(1'b0, "R2 corrupt copy 9", 1'b1);
        build(48'h0A0B0C0D0E0F, 5, 6, 16, 0, 5); frame(1'b0, "R4 other unicast", 1'b1);
        build(48'hFFFFFFFFFFFF, 5, 6, 16, 0, 5); frame(1'b1, "R4 broadcast", 1'b1);
        build(48'h01005E000001, 5, 6, 16, 0, 5); frame(1'b1, "R4 multicast", 1'b1);
        build(ME, 5, 6, 16, 0, 5);        frame(1'b0, "R5 bad CRC", 1'b0);
        build(ME, 5, 5, 16, 0, 5);        frame(1'b0, "R1 five sync bytes", 1'b1);
        build(ME, 5, 9, 16, 0, 5);        frame(1'b1, "R1 nine sync bytes", 1'b1);

        // R9: copies broken by 0xFF that starts a new valid sync
        build(ME, 5, 6, 9, 0, 0);
        put_pattern(6, 16, 0);
        put_fill(3);
        frame(1'b1, "R9 broken then resync", 1'b1);

        // R6: pending match dropped by a fresh start of frame
        build(ME, 5, 6, 16, 0, 5);
        drive(1'b1, 1'b0);
        build(ME, 5, 0, 0, 0, 30);
        frame(1'b0, "R6 new sof drops match", 1'b1);

        // R7: disarmed detector ignores a valid frame
        wake_magic_en = 1'b0;
        build(ME, 5, 6, 16, 0, 5);        frame(1'b0, "R7 disarmed", 1'b1);
        wake_magic_en = 1'b1;

        // R8: stickiness and release
        build(ME, 5, 6, 16, 0, 5);
        exp_q.push_back(1'b1); tag_q.push_back("R8 wake before hold");
        drive(1'b1, 1'b1);
        repeat (20) @(negedge clk);
        chk(wake_n == 1'b0, "R8 held low", wake_n, 1'b0);
        @(negedge clk); wake_clear = 1'b1;
        @(negedge clk); wake_clear = 1'b0;
        chk(wake_n == 1'b1, "R8 released by clear", wake_n, 1'b1);

        // R7: dropping an enable releases a pending wake
        build(ME, 5, 6, 16, 0, 5);
        exp_q.push_back(1'b1); tag_q.push_back("R7 wake before disarm");
        drive(1'b1, 1'b1);
        repeat (2) @(negedge clk);
        wake_global_en = 1'b0;
        @(negedge clk);
        chk(wake_n == 1'b1, "R7 disarm releases", wake_n, 1'b1);
        wake_global_en = 1'b1;

        repeat (5) @(negedge clk);
        if (exp_q.size() != 0) chk(1'b0, "scoreboard not drained", 1'b0, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule